// File: doc/BRIEF.md
# Colour Lookup Table Host Access Controller

This block is the host-facing register port of a colour lookup table. A host reaches it through an 8-bit data bus, split into an input, an output and an output enable, plus a 3-bit register select and single-cycle read and write strobes, all in the clock domain of the storage. The host first loads an address. It then moves colours as runs of three bytes, in the order red, green, blue. A hidden modulo-3 phase counter tracks which byte comes next. An 8-bit address register steps after every blue byte, so a whole table can be streamed from a single start address.

The block drives a 256-entry palette memory and a 16-slot overlay register file through plain read and write ports. Both storage read ports are combinational. Red and green written bytes wait in holding registers. The blue write stores all three as one 24-bit word. For reads, loading an address in read mode fetches the addressed entry into the holding registers ahead of time. Each blue read fetches the next entry. A command bit chooses full 8-bit components or 6-bit components carried on the low bus bits.

Top module: `clut_host_port`

## Requirements
- R1: After reset the address register reads 00h, the phase counter is at red, the command register reads 01h (8-bit mode), and hostDoutEn is low while hostRd is low.
- R2: Select codes work as follows. 000 loads the palette write address and 011 the palette read address. 100 loads the overlay write address and 111 the overlay read address. Reading any of these four codes returns the address register. 001 carries palette colour bytes and 101 carries overlay colour bytes. 110 is the command register, whose bit 0 is 1 for 8-bit mode and 0 for 6-bit mode. Code 010 reads as 00h and ignores writes. hostDout is valid in the same cycle as hostRd.
- R3: Any write of the address register returns the phase counter to red. Each colour data access advances it red, then green, then blue, then back to red.
- R4: Red and green writes are held internally. The blue write stores {red[23:16], green[15:8], blue[7:0]} at the current address with a one-cycle write strobe, and the address then increments by one.
- R5: Loading a read address fetches that entry into the holding registers and sets the address to the loaded value plus one. Each blue read fetches the entry at the current address and increments it again.
- R6: The address wraps from FFh to 00h after a blue access at FFh.
- R7: In overlay space only address bits 3:0 choose the slot. Bits 7:4 are kept in the address register and read back unchanged.
- R8: Reading the address register changes neither the address nor the phase counter.
- R9: In 6-bit mode a written byte uses bus bits 5:0, ignores bits 7:6, and is stored shifted left by two with its two low bits zero.
- R10: In 6-bit mode a colour read returns the stored component shifted right by two, so bus bits 7:6 read zero.
- R11: Overlay slot 0 is reserved. A blue write there asserts no overlay write strobe, and a fetch from it yields zeros. The address and phase counter still step normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the host and the storage |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 3 | Register select code |
| hostWr | input | 1 | Single-cycle host write strobe |
| hostRd | input | 1 | Single-cycle host read strobe |
| hostDin | input | 8 | Host write data |
| hostDout | output | 8 | Host read data |
| hostDoutEn | output | 1 | Bus drive enable, high during a read |
| palAddr | output | 8 | Palette memory address |
| palWe | output | 1 | Palette memory write strobe |
| palWdata | output | 24 | Palette write word |
| palRdata | input | 24 | Palette read word (combinational) |
| ovlAddr | output | 4 | Overlay register index |
| ovlWe | output | 1 | Overlay register write strobe |
| ovlWdata | output | 24 | Overlay write word |
| ovlRdata | input | 24 | Overlay read word (combinational) |

## Verification
The colour path is exercised in four ways. Sequential multi-entry write runs test that the phase counter and address stepping are separated correctly. Prefetched read runs over the same entries test whether the fetch lands before or after the increment. An overlay run with nonzero upper address bits tests that the slot index is truncated while the register keeps its full value. Targeted runs then cover the FFh wrap in both directions, an aborted byte run followed by a fresh address load, an address read placed in the middle of a run, 6-bit packing in both directions, and reserved slot 0.

// File: rtl/clut_host_pkg.sv
package clut_host_pkg;
  localparam int BUS_W    = 8;
  localparam int COMP_W   = BUS_W;
  localparam int ADDR_W   = BUS_W;
  localparam int OVL_AW   = 4;
  localparam int N_COMP   = 3;
  localparam int WORD_W   = COMP_W * N_COMP;
  localparam int LOW_BITS = 2;

  typedef enum logic [2:0] {
    SEL_PAL_WADDR = 3'b000,
    SEL_PAL_DATA  = 3'b001,
    SEL_UNUSED    = 3'b010,
    SEL_PAL_RADDR = 3'b011,
    SEL_OVL_WADDR = 3'b100,
    SEL_OVL_DATA  = 3'b101,
    SEL_CMD       = 3'b110,
    SEL_OVL_RADDR = 3'b111
  } hostSel_t;

  typedef struct packed {
    logic       latchByte;
    logic       fetch;
    logic       cmdWrite;
    logic [1:0] phase;
  } hostStrobes_t;
endpackage

// File: rtl/clut_host_ctrl.sv
module clut_host_ctrl
  import clut_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostSel_t          selCode,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [BUS_W-1:0]  hostDin,
  output hostStrobes_t      strobes,
  output logic              storeNow,
  output logic              toOverlay,
  output logic [ADDR_W-1:0] addrQ,
  output logic [ADDR_W-1:0] accessAddr
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);

  logic [1:0] phaseQ;
  logic isAddrSel, isDataSel, loadAddr, readAhead, dataWr, dataRd, lastPhase;

  always_comb begin
    isAddrSel = (selCode == SEL_PAL_WADDR) || (selCode == SEL_PAL_RADDR) ||
                (selCode == SEL_OVL_WADDR) || (selCode == SEL_OVL_RADDR);
    isDataSel = (selCode == SEL_PAL_DATA) || (selCode == SEL_OVL_DATA);
    toOverlay = selCode[2];
    loadAddr  = hostWr && isAddrSel;
    readAhead = hostWr && ((selCode == SEL_PAL_RADDR) || (selCode == SEL_OVL_RADDR));
    dataWr    = hostWr && isDataSel;
    dataRd    = hostRd && !hostWr && isDataSel;
    lastPhase = (phaseQ == 2'd2);
    storeNow  = dataWr && lastPhase;
    accessAddr = loadAddr ? hostDin : addrQ;

    strobes.latchByte = dataWr && !lastPhase;
    strobes.fetch     = readAhead || (dataRd && lastPhase);
    strobes.cmdWrite  = hostWr && (selCode == SEL_CMD);
    strobes.phase     = phaseQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      phaseQ <= 2'd0;
    end else if (loadAddr) begin
      addrQ  <= readAhead ? hostDin + ADDR_STEP : hostDin;
      phaseQ <= 2'd0;
    end else begin
      if (storeNow || strobes.fetch) addrQ <= addrQ + ADDR_STEP;
      if (dataWr || dataRd) phaseQ <= lastPhase ? 2'd0 : phaseQ + 2'd1;
    end
  end

  // R3: the phase counter never reaches the unused code
  a_r3_phase_legal: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ != 2'd3);

  // R3: an address load returns the counter to red
  a_r3_addr_load_clears_phase: assert property (@(posedge clk) disable iff (!rstN)
    loadAddr |=> phaseQ == 2'd0);

  // R8: an address read alone leaves address and phase untouched
  a_r8_addr_read_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostWr && isAddrSel) |=> ($stable(addrQ) && $stable(phaseQ)));

  // R4/R6: a stored entry moves the address on by one, modulo 256
  a_r4_store_steps_addr: assert property (@(posedge clk) disable iff (!rstN)
    storeNow |=> addrQ == $past(addrQ) + ADDR_STEP);
endmodule

// File: rtl/clut_host_dpath.sv
module clut_host_dpath
  import clut_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostSel_t          selCode,
  input  logic              hostRd,
  input  logic [BUS_W-1:0]  hostDin,
  input  hostStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addrQ,
  input  logic [WORD_W-1:0] fetchData,
  output logic [WORD_W-1:0] storeWord,
  output logic [BUS_W-1:0]  hostDout,
  output logic              hostDoutEn
);
  logic              cmdQ;
  logic [COMP_W-1:0] compQ [N_COMP];
  logic [COMP_W-1:0] widened;
  logic [COMP_W-1:0] selComp;

  assign widened   = cmdQ ? hostDin : {hostDin[COMP_W-LOW_BITS-1:0], {LOW_BITS{1'b0}}};
  assign storeWord = {compQ[0], compQ[1], widened};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cmdQ <= 1'b1;
    else if (strobes.cmdWrite) cmdQ <= hostDin[0];
  end

  for (genvar c = 0; c < N_COMP; c++) begin : g_hold
    localparam int HI = WORD_W - 1 - c * COMP_W;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        compQ[c] <= '0;
      else if (strobes.fetch)
        compQ[c] <= fetchData[HI -: COMP_W];
      else if (strobes.latchByte && strobes.phase == 2'(c))
        compQ[c] <= widened;
    end
  end

  always_comb begin
    case (strobes.phase)
      2'd0:    selComp = compQ[0];
      2'd1:    selComp = compQ[1];
      default: selComp = compQ[2];
    endcase
    case (selCode)
      SEL_PAL_DATA, SEL_OVL_DATA:
        hostDout = cmdQ ? selComp : {{LOW_BITS{1'b0}}, selComp[COMP_W-1:LOW_BITS]};
      SEL_CMD:    hostDout = {{(BUS_W-1){1'b0}}, cmdQ};
      SEL_UNUSED: hostDout = '0;
      default:    hostDout = addrQ;
    endcase
    hostDoutEn = hostRd;
  end

  // R10: colour reads in 6-bit mode leave the top two bus bits clear
  a_r10_six_bit_read_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !cmdQ && (selCode == SEL_PAL_DATA || selCode == SEL_OVL_DATA))
      |-> hostDout[BUS_W-1:BUS_W-LOW_BITS] == '0);
endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
  import clut_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [BUS_W-1:0]  hostDin,
  output logic [BUS_W-1:0]  hostDout,
  output logic              hostDoutEn,
  output logic [ADDR_W-1:0] palAddr,
  output logic              palWe,
  output logic [WORD_W-1:0] palWdata,
  input  logic [WORD_W-1:0] palRdata,
  output logic [OVL_AW-1:0] ovlAddr,
  output logic              ovlWe,
  output logic [WORD_W-1:0] ovlWdata,
  input  logic [WORD_W-1:0] ovlRdata
);
  hostSel_t          selCode;
  hostStrobes_t      strobes;
  logic              storeNow, toOverlay, ovlReserved;
  logic [ADDR_W-1:0] addrQ, accessAddr;
  logic [WORD_W-1:0] fetchData, storeWord;

  assign selCode     = hostSel_t'(hostSel);
  assign palAddr     = accessAddr;
  assign ovlAddr     = accessAddr[OVL_AW-1:0];
  assign ovlReserved = (ovlAddr == '0);
  assign fetchData   = toOverlay ? (ovlReserved ? '0 : ovlRdata) : palRdata;
  assign palWe       = storeNow && !toOverlay;
  assign ovlWe       = storeNow && toOverlay && !ovlReserved;
  assign palWdata    = storeWord;
  assign ovlWdata    = storeWord;

  clut_host_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .selCode(selCode), .hostWr(hostWr), .hostRd(hostRd),
    .hostDin(hostDin), .strobes(strobes), .storeNow(storeNow), .toOverlay(toOverlay),
    .addrQ(addrQ), .accessAddr(accessAddr)
  );

  clut_host_dpath dpath_i (
    .clk(clk), .rstN(rstN), .selCode(selCode), .hostRd(hostRd), .hostDin(hostDin),
    .strobes(strobes), .addrQ(addrQ), .fetchData(fetchData), .storeWord(storeWord),
    .hostDout(hostDout), .hostDoutEn(hostDoutEn)
  );
endmodule

// File: tb/clut_host_port_tb.sv
module clut_host_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  hostSel = 3'b010;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0]  hostDin = '0, hostDout;
  logic        hostDoutEn, palWe, ovlWe;
  logic [7:0]  palAddr;
  logic [3:0]  ovlAddr;
  logic [23:0] palWdata, palRdata, ovlWdata, ovlRdata;
  logic [23:0] palMem [256];
  logic [23:0] ovlMem [16];
  int nChecks = 0, nFail = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  clut_host_port dut_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostDin(hostDin), .hostDout(hostDout), .hostDoutEn(hostDoutEn),
    .palAddr(palAddr), .palWe(palWe), .palWdata(palWdata), .palRdata(palRdata),
    .ovlAddr(ovlAddr), .ovlWe(ovlWe), .ovlWdata(ovlWdata), .ovlRdata(ovlRdata)
  );

  assign palRdata = palMem[palAddr];
  assign ovlRdata = ovlMem[ovlAddr];
  always @(posedge clk) begin
    if (palWe) palMem[palAddr] <= palWdata;
    if (ovlWe) ovlMem[ovlAddr] <= ovlWdata;
  end

  // {op(1: read-and-compare), sel(3), write data(8), expected read(8)}
  localparam int NVEC = 27;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0,3'd0,8'h10,8'h00}, {1'b0,3'd1,8'h11,8'h00}, {1'b0,3'd1,8'h22,8'h00},
    {1'b0,3'd1,8'h33,8'h00}, {1'b0,3'd1,8'h44,8'h00}, {1'b0,3'd1,8'h55,8'h00},
    {1'b0,3'd1,8'h66,8'h00}, {1'b1,3'd0,8'h00,8'h12}, {1'b0,3'd3,8'h10,8'h00},
    {1'b1,3'd3,8'h00,8'h11}, {1'b1,3'd1,8'h00,8'h11}, {1'b1,3'd1,8'h00,8'h22},
    {1'b1,3'd1,8'h00,8'h33}, {1'b1,3'd1,8'h00,8'h44}, {1'b1,3'd1,8'h00,8'h55},
    {1'b1,3'd1,8'h00,8'h66}, {1'b1,3'd0,8'h00,8'h13}, {1'b0,3'd4,8'h23,8'h00},
    {1'b1,3'd4,8'h00,8'h23}, {1'b0,3'd5,8'hAA,8'h00}, {1'b0,3'd5,8'hBB,8'h00},
    {1'b0,3'd5,8'hCC,8'h00}, {1'b1,3'd4,8'h00,8'h24}, {1'b0,3'd7,8'h13,8'h00},
    {1'b1,3'd5,8'h00,8'hAA}, {1'b1,3'd5,8'h00,8'hBB}, {1'b1,3'd5,8'h00,8'hCC}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    hostSel = sel; hostDin = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] sel, output logic [7:0] v);
    @(negedge clk);
    hostSel = sel; hostRd = 1'b1;
    #2 v = hostDout;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) palMem[i] = '0;
    for (int i = 0; i < 16; i++) ovlMem[i] = '0;
    ovlMem[0] = 24'h5A5A5A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #2 chk("R1 idle bus enable", 32'(hostDoutEn), 32'd0);
    hostRead(3'd0, rv); chk("R1 address after reset", 32'(rv), 32'h00);
    hostRead(3'd6, rv); chk("R1 command after reset", 32'(rv), 32'h01);
    hostRead(3'd2, rv); chk("R2 unused select reads zero", 32'(rv), 32'h00);

    // vector table: R2 R3 R4 R5 R7
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][19]) begin
        hostRead(VEC[i][18:16], rv);
        chk($sformatf("R2/R4/R5/R7 vector %0d", i), 32'(rv), 32'(VEC[i][7:0]));
      end else
        hostWrite(VEC[i][18:16], VEC[i][15:8]);
    end
    chk("R4 palette entry 10h", 32'(palMem[8'h10]), 32'h112233);
    chk("R4 palette entry 11h", 32'(palMem[8'h11]), 32'h445566);
    chk("R7 overlay slot 3 from address 23h", 32'(ovlMem[3]), 32'hAABBCC);

    // R6 wrap on write and on read
    hostWrite(3'd0, 8'hFF);
    hostWrite(3'd1, 8'h01); hostWrite(3'd1, 8'h02); hostWrite(3'd1, 8'h03);
    hostRead(3'd0, rv); chk("R6 write wrap address", 32'(rv), 32'h00);
    chk("R6 entry FFh stored", 32'(palMem[8'hFF]), 32'h010203);
    hostWrite(3'd3, 8'hFF);
    hostRead(3'd0, rv); chk("R6 prefetch wrap address", 32'(rv), 32'h00);
    hostRead(3'd1, rv); chk("R6 read red at FFh", 32'(rv), 32'h01);
    hostRead(3'd1, rv); hostRead(3'd1, rv); chk("R6 read blue at FFh", 32'(rv), 32'h03);
    hostRead(3'd0, rv); chk("R5 address after blue read", 32'(rv), 32'h01);

    // R3 aborted run then reload
    hostWrite(3'd0, 8'h20); hostWrite(3'd1, 8'h77);
    hostWrite(3'd0, 8'h20);
    hostWrite(3'd1, 8'h01); hostWrite(3'd1, 8'h02); hostWrite(3'd1, 8'h03);
    chk("R3 reload restarts at red", 32'(palMem[8'h20]), 32'h010203);

    // R8 address read mid-run
    hostWrite(3'd0, 8'h30); hostWrite(3'd1, 8'hA1);
    hostRead(3'd0, rv); chk("R8 address read mid-run", 32'(rv), 32'h30);
    hostWrite(3'd1, 8'hB2); hostWrite(3'd1, 8'hC3);
    chk("R8 run undisturbed", 32'(palMem[8'h30]), 32'hA1B2C3);

    // R9 / R10 six-bit mode
    hostWrite(3'd6, 8'h00);
    hostRead(3'd6, rv); chk("R2 command readback", 32'(rv), 32'h00);
    hostWrite(3'd0, 8'h40);
    hostWrite(3'd1, 8'hFF); hostWrite(3'd1, 8'hC1); hostWrite(3'd1, 8'h3F);
    chk("R9 six-bit packing", 32'(palMem[8'h40]), 32'hFC04FC);
    hostWrite(3'd3, 8'h40);
    hostRead(3'd1, rv); chk("R10 six-bit red", 32'(rv), 32'h3F);
    hostRead(3'd1, rv); chk("R10 six-bit green", 32'(rv), 32'h01);
    hostWrite(3'd3, 8'h10);
    hostRead(3'd1, rv); chk("R10 narrowed red", 32'(rv), 32'h04);
    hostRead(3'd1, rv); chk("R10 narrowed green", 32'(rv), 32'h08);
    hostRead(3'd1, rv); chk("R10 narrowed blue", 32'(rv), 32'h0C);
    hostWrite(3'd6, 8'h01);

    // R11 reserved overlay slot
    hostWrite(3'd4, 8'h00);
    hostWrite(3'd5, 8'h11); hostWrite(3'd5, 8'h22); hostWrite(3'd5, 8'h33);
    chk("R11 slot 0 unchanged", 32'(ovlMem[0]), 32'h5A5A5A);
    hostRead(3'd4, rv); chk("R11 address steps after slot 0", 32'(rv), 32'h01);
    hostWrite(3'd7, 8'h00);
    hostRead(3'd5, rv); chk("R11 slot 0 red zero", 32'(rv), 32'h00);
    hostRead(3'd5, rv); hostRead(3'd5, rv); chk("R11 slot 0 blue zero", 32'(rv), 32'h00);
    hostRead(3'd4, rv); chk("R11 address after slot 0 read", 32'(rv), 32'h02);

    finishRun();
  end
endmodule